// File: doc/BRIEF.md
# Layer Completion Sequencer for Dual-Rail Binary Neurons

This block coordinates evaluation across the layers of a network built from dual-rail binary neurons, with no timing assumptions. Each neuron drives an excitatory rail and an inhibitory rail. Both rails are low while the neuron precharges, and one of them rises once the neuron has decided. The block treats a neuron as finished when either of its rails is high. A layer counts as finished when all of its neurons are finished.

A layer may evaluate only after the layer before it has finished. A strobe that announces a new network input starts a global precharge. The precharge holds for a configurable number of cycles and then releases the first layer. Completion then ripples forward one layer per cycle until the last layer finishes, which raises a network-done flag.

A neuron that shows both rails high is malformed. It raises a sticky error flag but still counts as finished. The logic is modelled as a synchronous circuit for simulation; the neuron circuits themselves are outside the block.

Top module: `layer_completion_ctrl`

## Requirements
- R1: A high `new_input` sampled on a clock edge makes `precharge_o` high after that edge, and clears `eval_en_o`, `net_done_o` and `rail_err_o` to 0.
- R2: After the last strobe, `precharge_o` stays high for exactly `RESET_CYCLES` cycles. On the edge that ends it, `eval_en_o[0]` rises. A strobe during precharge restarts the count.
- R3: A neuron counts as finished when its excitatory rail or its inhibitory rail is 1. Either rail alone is enough.
- R4: Layer k counts as finished only when every one of its neurons is finished. Once `eval_en_o[k]` is 1 and layer k is finished, `eval_en_o[k+1]` becomes 1 one cycle later. Neuron j of layer k uses bit k*NEURONS+j of both rail buses.
- R5: Rails of a layer whose enable is 0 have no effect. While `eval_en_o[k]` is 0, `eval_en_o[k+1]`, `net_done_o` and `rail_err_o` are not affected by layer k.
- R6: `net_done_o` becomes 1 one cycle after the last layer is enabled and finished. It stays 1 until the next strobe.
- R7: If any neuron of an enabled layer has both rails at 1, `rail_err_o` becomes 1 one cycle later and stays set until the next strobe. That neuron still counts as finished.
- R8: A strobe during evaluation or after completion restarts the whole sequence from precharge.
- R9: After reset, all outputs are 0 and the block waits for a strobe.
- R10: Enables are ordered. `eval_en_o[k+1]` is never 1 while `eval_en_o[k]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_input | input | 1 | Strobe announcing a new network input |
| rail_exc | input | NUM_LAYERS*NEURONS | Excitatory rail of every neuron, layer-major |
| rail_inh | input | NUM_LAYERS*NEURONS | Inhibitory rail of every neuron, layer-major |
| precharge_o | output | 1 | Global precharge for all neurons |
| eval_en_o | output | NUM_LAYERS | Per-layer evaluation enable |
| net_done_o | output | 1 | Final layer has finished |
| rail_err_o | output | 1 | Some enabled neuron showed both rails high |

## Verification
The first pattern drives every neuron on its excitatory rail only. A second pattern alternates the two rails between neurons. Comparing these shows that completion is independent of which rail fires. A third pattern leaves one neuron of a middle layer silent and then lets it finish late. This separates a true all-neurons reduction from any-neuron logic. It also shows that the completed layers behind the silent one stay blocked. The last patterns place a conflicting neuron inside an enabled layer and inside a blocked layer, and strobe during precharge and during evaluation. These tell gated error capture apart from raw capture, and a restart apart from a plain continuation.

// File: rtl/lcd_pkg.sv
// Package: shared types for the layer completion sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package lcd_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_PRECHARGE = 2'd1,
        SEQ_EVAL      = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lcd_layer_reduce.sv
// Module: completion reduction for one layer of dual-rail neurons.
// Per neuron, finished = either rail high; a clash = both rails high.
// The layer is finished when every neuron is finished; the clash flag
// is the OR over all neurons. Purely combinational; assumes the rails
// are stable while the layer evaluates.
module lcd_layer_reduce #(
    parameter int NEURONS = 4
) (
    input  logic [NEURONS-1:0] exc_i,
    input  logic [NEURONS-1:0] inh_i,
    output logic               layer_done_o,
    output logic               layer_clash_o
);
    logic [NEURONS-1:0] fin;
    logic [NEURONS-1:0] clash;

    // Per-neuron completion and clash detection.
    for (genvar j = 0; j < NEURONS; j++) begin : g_neuron
        assign fin[j]   = exc_i[j] | inh_i[j];
        assign clash[j] = exc_i[j] & inh_i[j];
    end

    // AND tree over completions, OR tree over clashes.
    always_comb begin
        layer_done_o  = &fin;
        layer_clash_o = |clash;
    end
endmodule

// File: rtl/lcd_precharge_seq.sv
// Module: precharge sequencer. A strobe (any state) enters precharge
// for RESET_CYCLES cycles; afterwards a one-cycle start pulse releases
// the first layer. Assumes RESET_CYCLES >= 1.
module lcd_precharge_seq
    import lcd_pkg::*;
#(
    parameter int RESET_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic new_input,
    output logic precharge_o,
    output logic start_o
);
    localparam int CW = $clog2(RESET_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RESET_CYCLES - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // State and hold counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (new_input) begin
            state_q <= SEQ_PRECHARGE;
            cnt_q   <= CNT_LOAD;
        end else if (state_q == SEQ_PRECHARGE) begin
            if (cnt_q == '0) state_q <= SEQ_EVAL;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        precharge_o = (state_q == SEQ_PRECHARGE);
        start_o     = (state_q == SEQ_PRECHARGE) && (cnt_q == '0) && !new_input;
    end

    // Checker: length of the current precharge run.
    logic [CW:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || new_input) run_len_q <= '0;
        else if (precharge_o)    run_len_q <= run_len_q + 1'b1;
    end

    p_strobe_prech_r1: assert property (@(posedge clk) disable iff (!rst_n)
        new_input |=> precharge_o);

    p_prech_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(precharge_o) && !$past(new_input)) |-> (run_len_q == (CW+1)'(RESET_CYCLES)));
endmodule

// File: rtl/lcd_layer_chain.sv
// Module: layer enable chain. Layer 0 is enabled by the start pulse;
// layer k+1 by layer k being enabled and finished. Also produces the
// network-done and sticky rail error flags. A clear (strobe) drops
// everything. Assumes rails of an enabled layer do not fall.
module lcd_layer_chain #(
    parameter int NUM_LAYERS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  start_i,
    input  logic [NUM_LAYERS-1:0] layer_done_i,
    input  logic [NUM_LAYERS-1:0] layer_clash_i,
    output logic [NUM_LAYERS-1:0] eval_en_o,
    output logic                  net_done_o,
    output logic                  rail_err_o
);
    localparam int LAST = NUM_LAYERS - 1;

    logic [NUM_LAYERS-1:0] en_q;
    logic                  done_q;
    logic                  err_q;

    // First layer enable: set by start, dropped by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) en_q[0] <= 1'b0;
        else if (start_i)      en_q[0] <= 1'b1;
    end

    // Downstream enables: set when the previous layer completes.
    for (genvar k = 1; k < NUM_LAYERS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)                        en_q[k] <= 1'b0;
            else if (en_q[k-1] && layer_done_i[k-1])      en_q[k] <= 1'b1;
        end

        p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
            eval_en_o[k] |-> eval_en_o[k-1]);

        p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (eval_en_o[k-1] && layer_done_i[k-1] && !clear_i) |=> eval_en_o[k]);

        p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !eval_en_o[k-1] |=> !eval_en_o[k]);
    end

    // Network-done flag: final layer enabled and finished.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)                   done_q <= 1'b0;
        else if (en_q[LAST] && layer_done_i[LAST]) done_q <= 1'b1;
    end

    // Sticky error: clash seen inside an enabled layer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)          err_q <= 1'b0;
        else if (|(en_q & layer_clash_i)) err_q <= 1'b1;
    end

    assign eval_en_o  = en_q;
    assign net_done_o = done_q;
    assign rail_err_o = err_q;

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (eval_en_o == '0 && !net_done_o && !rail_err_o));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (net_done_o && !clear_i) |=> net_done_o);

    p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en_o[LAST] && layer_done_i[LAST] && !clear_i) |=> net_done_o);

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(eval_en_o & layer_clash_i)) && !clear_i) |=> rail_err_o);
endmodule

// File: rtl/layer_completion_ctrl.sv
// Module: top of the layer completion sequencer. Splits the flat
// layer-major rail buses per layer, reduces each layer to a finished
// and a clash flag, and drives the precharge sequencer and enable chain.
// Assumes rails are held stable by the neurons once evaluated.
module layer_completion_ctrl #(
    parameter int NUM_LAYERS   = 3,
    parameter int NEURONS      = 4,
    parameter int RESET_CYCLES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          new_input,
    input  logic [NUM_LAYERS*NEURONS-1:0] rail_exc,
    input  logic [NUM_LAYERS*NEURONS-1:0] rail_inh,
    output logic                          precharge_o,
    output logic [NUM_LAYERS-1:0]         eval_en_o,
    output logic                          net_done_o,
    output logic                          rail_err_o
);
    logic [NUM_LAYERS-1:0] layer_done;
    logic [NUM_LAYERS-1:0] layer_clash;
    logic                  start;

    // One reduction per layer.
    for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
        lcd_layer_reduce #(.NEURONS(NEURONS)) u_reduce (
            .exc_i         (rail_exc[k*NEURONS +: NEURONS]),
            .inh_i         (rail_inh[k*NEURONS +: NEURONS]),
            .layer_done_o  (layer_done[k]),
            .layer_clash_o (layer_clash[k])
        );
    end

    lcd_precharge_seq #(.RESET_CYCLES(RESET_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .new_input   (new_input),
        .precharge_o (precharge_o),
        .start_o     (start)
    );

    lcd_layer_chain #(.NUM_LAYERS(NUM_LAYERS)) u_chain (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (new_input),
        .start_i       (start),
        .layer_done_i  (layer_done),
        .layer_clash_i (layer_clash),
        .eval_en_o     (eval_en_o),
        .net_done_o    (net_done_o),
        .rail_err_o    (rail_err_o)
    );

    p_prech_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        precharge_o |-> (eval_en_o == '0));
endmodule

// File: tb/layer_completion_ctrl_tb_top.sv
// Directed bench for layer_completion_ctrl: 3 layers x 4 neurons,
// precharge of 3 cycles. Inputs driven and outputs sampled 2 ns after
// each rising edge.
module layer_completion_ctrl_tb_top;
    localparam int L  = 3;
    localparam int N  = 4;
    localparam int RC = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           new_input = 1'b0;
    logic [L*N-1:0] rail_exc = '0;
    logic [L*N-1:0] rail_inh = '0;
    logic           precharge_o;
    logic [L-1:0]   eval_en_o;
    logic           net_done_o;
    logic           rail_err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    layer_completion_ctrl #(.NUM_LAYERS(L), .NEURONS(N), .RESET_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .new_input(new_input),
        .rail_exc(rail_exc), .rail_inh(rail_inh),
        .precharge_o(precharge_o), .eval_en_o(eval_en_o),
        .net_done_o(net_done_o), .rail_err_o(rail_err_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic strobe();
        new_input = 1'b1;
        step();
        new_input = 1'b0;
    endtask

    // Strobe, then walk through precharge; ends with layer 0 enabled.
    task automatic precharge_phase(input string req);
        strobe();
        check(req, "prech after strobe", 32'(precharge_o), 1);
        check(req, "enables cleared", 32'(eval_en_o), 0);
        check(req, "done cleared", 32'(net_done_o), 0);
        for (int i = 1; i < RC; i++) begin
            step();
            check(req, "prech held", 32'(precharge_o), 1);
        end
        step();
        check(req, "prech ended", 32'(precharge_o), 0);
        check(req, "layer0 enabled", 32'(eval_en_o), 1);
    endtask

    task automatic t_reset();
        check("R9", "reset prech", 32'(precharge_o), 0);
        check("R9", "reset enables", 32'(eval_en_o), 0);
        check("R9", "reset done", 32'(net_done_o), 0);
        check("R9", "reset err", 32'(rail_err_o), 0);
    endtask

    task automatic t_basic();
        rail_exc = '1; rail_inh = '0;
        precharge_phase("R2");
        step(); check("R4", "layer1 enabled", 32'(eval_en_o), 3);
        step(); check("R4", "layer2 enabled", 32'(eval_en_o), 7);
        step(); check("R6", "done set", 32'(net_done_o), 1);
        for (int i = 0; i < 3; i++) begin
            step(); check("R6", "done held", 32'(net_done_o), 1);
        end
        check("R7", "no err", 32'(rail_err_o), 0);
    endtask

    task automatic t_restart();
        strobe();
        check("R8", "restart prech", 32'(precharge_o), 1);
        check("R8", "restart enables", 32'(eval_en_o), 0);
        check("R8", "restart done", 32'(net_done_o), 0);
        // Restart in the middle of evaluation.
        for (int i = 0; i < RC + 1; i++) step();
        check("R8", "mid eval", 32'(eval_en_o), 3);
        strobe();
        check("R8", "mid restart prech", 32'(precharge_o), 1);
        check("R8", "mid restart enables", 32'(eval_en_o), 0);
    endtask

    task automatic t_mixed();
        rail_exc = 12'b1010_0101_1100;
        rail_inh = ~rail_exc;
        precharge_phase("R3");
        step(); check("R3", "mixed layer1", 32'(eval_en_o), 3);
        step(); check("R3", "mixed layer2", 32'(eval_en_o), 7);
        step(); check("R3", "mixed done", 32'(net_done_o), 1);
    endtask

    task automatic t_incomplete();
        rail_exc = '1; rail_inh = '0;
        rail_exc[1*N+2] = 1'b0;
        precharge_phase("R4");
        step(); check("R4", "layer1 on", 32'(eval_en_o), 3);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R5", "layer2 blocked", 32'(eval_en_o), 3);
            check("R5", "done blocked", 32'(net_done_o), 0);
        end
        rail_inh[1*N+2] = 1'b1;
        step(); check("R4", "late finish", 32'(eval_en_o), 7);
        step(); check("R6", "late done", 32'(net_done_o), 1);
    endtask

    task automatic t_conflict();
        rail_exc = '1; rail_inh = '0;
        rail_inh[0] = 1'b1;
        precharge_phase("R7");
        check("R7", "err not yet", 32'(rail_err_o), 0);
        step();
        check("R7", "err set", 32'(rail_err_o), 1);
        check("R7", "clash counts finished", 32'(eval_en_o), 3);
        step(); step();
        check("R7", "err sticky", 32'(rail_err_o), 1);
        check("R7", "done with clash", 32'(net_done_o), 1);
        strobe();
        check("R1", "err cleared", 32'(rail_err_o), 0);
    endtask

    task automatic t_blocked_conflict();
        rail_exc = '1; rail_inh = '0;
        rail_exc[1*N+1] = 1'b0;
        rail_inh[2*N+3] = 1'b1;
        precharge_phase("R5");
        for (int i = 0; i < 4; i++) step();
        check("R5", "blocked clash ignored", 32'(rail_err_o), 0);
        check("R5", "still blocked", 32'(eval_en_o), 3);
    endtask

    task automatic t_extend();
        rail_exc = '1; rail_inh = '0;
        strobe();
        step();
        check("R2", "prech 2nd cycle", 32'(precharge_o), 1);
        strobe();
        for (int i = 1; i < RC; i++) begin
            step(); check("R2", "extended prech", 32'(precharge_o), 1);
        end
        step();
        check("R2", "extended end", 32'(precharge_o), 0);
        check("R2", "extended release", 32'(eval_en_o), 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_restart();
        t_mixed();
        t_incomplete();
        t_conflict();
        t_blocked_conflict();
        t_extend();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule